// File: doc/BRIEF.md
# Multi-standard sub-pixel interpolation filter

This block is the one-dimensional filtering core of a video motion-compensation interpolator. On every cycle with `in_valid` high it takes a window of eight reference samples and a filter selection, and three clock edges later it delivers one interpolated sample. A two-bit mode chooses among four filter families: HEVC luma eight-tap, HEVC chroma four-tap, H.264/AVC luma six-tap and MPEG-4 eight-tap. A three-bit phase picks the fractional position. The caller does the 2-D sequencing and reference fetch and feeds the rows or columns one window at a time.

No general multiplier is used. Each tap is a shift-and-add product whose coefficient is looked up at run time, and an adder tree sums the eight products. A final stage applies the rounding, normalisation and clipping rules of the selected standard. The mode, phase and rounding control travel down the pipeline with each sample. Consecutive samples may therefore use different standards without a flush or a bubble.

Window packing: sample i sits at bits `[i*BIT_DEPTH +: BIT_DEPTH]`. Tap 0 is three positions left of the aligned full sample, and tap 3 is the aligned full sample itself.

Top module: `mc_subpel_filter`

## Requirements
- R1: A window sampled with `in_valid` high on a rising edge produces `out_valid` high and its result after the third following rising edge, and a new window can be accepted on every edge.
- R2: Mode 0 (HEVC luma) uses `in_phase[1:0]` only, and `in_phase[2]` has no effect. Value 1 selects taps {-1,4,-10,58,17,-5,1,0}, value 2 selects {-1,4,-11,40,40,-11,4,-1} and value 3 selects {0,1,-5,17,58,-10,4,-1}. The output is the signed sum shifted right by BIT_DEPTH-8, without clipping.
- R3: Mode 1 (HEVC chroma) uses all three phase bits as an eighth-sample position and applies four coefficients to taps 2..5. These are {-2,58,10,-2}, {-4,54,16,-2}, {-6,46,28,-4}, {-4,36,36,-4}, {-4,28,46,-6}, {-2,16,54,-4} and {-2,10,58,-2} for phases 1 to 7. Taps 0, 1, 6 and 7 have no effect, and normalisation is as in R2.
- R4: Mode 2 (H.264/AVC) applies {0,1,-5,20,20,-5,1,0} for any nonzero `in_phase[1:0]`. The output is (sum+16)>>5 with arithmetic shift, clipped to 0..2^BIT_DEPTH-1. Taps 0 and 7 have no effect.
- R5: Mode 3 (MPEG-4) applies {-1,3,-6,20,20,-6,3,-1} for any nonzero `in_phase[1:0]`. The output is (sum+16-in_rnd)>>5, clipped to 0..2^BIT_DEPTH-1. `in_rnd` has no effect in the other modes.
- R6: A zero fractional position bypasses the filter. For mode 1 that is a phase of 0; for the other modes it is `in_phase[1:0]` equal to 0. Modes 0 and 1 then output tap 3 shifted left by 14-BIT_DEPTH, and modes 2 and 3 output tap 3 unchanged.
- R7: Mode, phase and rounding control are taken per sample, so back-to-back windows in different modes each get their own filter.
- R8: While `rst_n` is low at a rising edge, and until a valid window has had time to pass through, `out_valid` is low.
- R9: A cycle with `in_valid` low yields a cycle with `out_valid` low three edges later, so gaps in the input are kept in the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window and controls are valid this cycle |
| in_mode | input | 2 | Filter family: 0 HEVC luma, 1 HEVC chroma, 2 AVC, 3 MPEG-4 |
| in_phase | input | 3 | Fractional position (eighths for chroma, low two bits for the others) |
| in_rnd | input | 1 | MPEG-4 rounding control |
| in_window | input | 8*BIT_DEPTH | Eight reference samples, tap 0 in the low bits |
| out_valid | output | 1 | Result is valid |
| out_sample | output | 16 | Filtered sample, signed |

## Verification
The hardest case to reach is the one where both clip limits of the AVC and MPEG-4 paths are hit in the same run while the mode changes on every cycle. Random windows rarely push the sum past either limit. The stimulus therefore includes windows with peaks on the centre taps and on the negative-weight taps, giving sums far above the top limit and far below zero. These are followed by a long random stretch in which the mode, phase, rounding bit, unused taps and valid gaps all change on each cycle.

// File: rtl/subpel_pkg.sv
// Shared types and the coefficient lookup for the sub-pixel filter.
// Assumes an eight-tap window; shorter filters place zeros on unused taps.
package subpel_pkg;

    typedef enum logic [1:0] {
        MODE_HEVC_Y  = 2'd0,
        MODE_HEVC_C  = 2'd1,
        MODE_AVC     = 2'd2,
        MODE_MP4     = 2'd3
    } mode_e;

    localparam int NTAPS = 8;

    // Coefficient for one tap given mode and phase; zero at full-sample phase.
    function automatic logic signed [7:0] coef_of(mode_e m, logic [2:0] ph, logic [2:0] tap);
        int c [8];
        c = '{0, 0, 0, 0, 0, 0, 0, 0};
        case (m)
            MODE_HEVC_Y: begin
                case (ph[1:0])
                    2'd1: c = '{-1, 4, -10, 58, 17, -5, 1, 0};
                    2'd2: c = '{-1, 4, -11, 40, 40, -11, 4, -1};
                    2'd3: c = '{0, 1, -5, 17, 58, -10, 4, -1};
                    default: ;
                endcase
            end
            MODE_HEVC_C: begin
                case (ph)
                    3'd1: c = '{0, 0, -2, 58, 10, -2, 0, 0};
                    3'd2: c = '{0, 0, -4, 54, 16, -2, 0, 0};
                    3'd3: c = '{0, 0, -6, 46, 28, -4, 0, 0};
                    3'd4: c = '{0, 0, -4, 36, 36, -4, 0, 0};
                    3'd5: c = '{0, 0, -4, 28, 46, -6, 0, 0};
                    3'd6: c = '{0, 0, -2, 16, 54, -4, 0, 0};
                    3'd7: c = '{0, 0, -2, 10, 58, -2, 0, 0};
                    default: ;
                endcase
            end
            MODE_AVC: begin
                if (ph[1:0] != 2'd0) c = '{0, 1, -5, 20, 20, -5, 1, 0};
            end
            default: begin
                if (ph[1:0] != 2'd0) c = '{-1, 3, -6, 20, 20, -6, 3, -1};
            end
        endcase
        return 8'(c[tap]);
    endfunction

endpackage

// File: rtl/subpel_tap_mul.sv
// Multiplies one unsigned sample by a signed run-time coefficient using
// only shifts and adds. Assumes coefficient magnitude below 128.
module subpel_tap_mul #(
    parameter int BIT_DEPTH = 8,
    parameter int PROD_W    = BIT_DEPTH + 8
) (
    input  logic [BIT_DEPTH-1:0]     x,
    input  logic signed [7:0]        coef,
    output logic signed [PROD_W-1:0] prod
);
    logic              neg;
    logic [6:0]        mag;
    logic [PROD_W-1:0] acc;

    // Split the coefficient into sign and magnitude.
    always_comb begin
        neg = coef[7];
        mag = neg ? 7'(-coef) : coef[6:0];
    end

    // Accumulate shifted copies of the sample for each set magnitude bit.
    always_comb begin
        acc = '0;
        for (int b = 0; b < 7; b++) begin
            if (mag[b]) acc = acc + (PROD_W'(x) << b);
        end
        prod = neg ? -signed'(acc) : signed'(acc);
    end
endmodule

// File: rtl/subpel_adder_tree.sv
// Balanced binary adder tree over N signed products (N a power of two).
// Purely combinational; the caller registers the result.
module subpel_adder_tree #(
    parameter int N     = 8,
    parameter int IN_W  = 16,
    parameter int OUT_W = IN_W + $clog2(N)
) (
    input  logic signed [IN_W-1:0]  terms [N],
    output logic signed [OUT_W-1:0] total
);
    localparam int LEVELS = $clog2(N);

    logic signed [OUT_W-1:0] node [LEVELS+1][N];

    genvar l, j;
    generate
        for (j = 0; j < N; j++) begin : g_leaf
            assign node[0][j] = OUT_W'(terms[j]);
        end
        for (l = 0; l < LEVELS; l++) begin : g_level
            for (j = 0; j < N; j++) begin : g_node
                if (j < (N >> (l + 1))) begin : g_add
                    assign node[l+1][j] = node[l][2*j] + node[l][2*j+1];
                end else begin : g_pad
                    assign node[l+1][j] = '0;
                end
            end
        end
    endgenerate

    assign total = node[LEVELS][0];
endmodule

// File: rtl/subpel_round_clip.sv
// Final normalisation: HEVC intermediate scaling, or rounded shift and
// clip for AVC and MPEG-4; also handles the full-sample bypass.
module subpel_round_clip
    import subpel_pkg::*;
#(
    parameter int BIT_DEPTH = 8,
    parameter int SUM_W     = BIT_DEPTH + 11,
    parameter int OUT_W     = 16
) (
    input  mode_e                   mode,
    input  logic                    rnd,
    input  logic                    bypass,
    input  logic [BIT_DEPTH-1:0]    center,
    input  logic signed [SUM_W-1:0] sum,
    output logic signed [OUT_W-1:0] result
);
    localparam int HEVC_SH = BIT_DEPTH - 8;
    localparam int UPSCALE = 14 - BIT_DEPTH;
    localparam int MAXV    = (1 << BIT_DEPTH) - 1;
    localparam logic signed [SUM_W:0] MAXQ = (SUM_W+1)'(MAXV);

    logic signed [SUM_W:0] biased;
    logic signed [SUM_W:0] shifted;
    logic                  is_hevc;

    // Add the rounding offset (minus the MPEG-4 control) and shift by five.
    always_comb begin
        biased  = (SUM_W+1)'(sum) + (SUM_W+1)'(16)
                - (SUM_W+1)'((mode == MODE_MP4) && rnd);
        shifted = biased >>> 5;
    end

    // Pick the output according to family and bypass.
    always_comb begin
        is_hevc = (mode == MODE_HEVC_Y) || (mode == MODE_HEVC_C);
        if (is_hevc) begin
            if (bypass) result = OUT_W'(center) << UPSCALE;
            else        result = OUT_W'(sum >>> HEVC_SH);
        end else if (bypass) begin
            result = OUT_W'(center);
        end else if (shifted < 0) begin
            result = '0;
        end else if (shifted > MAXQ) begin
            result = OUT_W'(MAXV);
        end else begin
            result = OUT_W'(shifted);
        end
    end
endmodule

// File: rtl/mc_subpel_filter.sv
// Reconfigurable four-stage interpolation filter: capture, per-tap
// shift-add products, adder tree, round/clip. Assumes BIT_DEPTH <= 10 so
// the HEVC intermediate fits the 16-bit output.
module mc_subpel_filter
    import subpel_pkg::*;
#(
    parameter int BIT_DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 in_mode,
    input  logic [2:0]                 in_phase,
    input  logic                       in_rnd,
    input  logic [8*BIT_DEPTH-1:0]     in_window,
    output logic                       out_valid,
    output logic signed [15:0]         out_sample
);
    localparam int PROD_W  = BIT_DEPTH + 8;
    localparam int SUM_W   = PROD_W + $clog2(NTAPS);
    localparam int UPSCALE = 14 - BIT_DEPTH;
    localparam int MAXV    = (1 << BIT_DEPTH) - 1;

    // Stage 1: captured inputs
    logic                 s1_valid, s1_rnd;
    mode_e                s1_mode;
    logic [2:0]           s1_phase;
    logic [BIT_DEPTH-1:0] s1_win [NTAPS];
    logic                 s1_bypass;
    logic signed [7:0]    s1_coef [NTAPS];
    logic signed [PROD_W-1:0] s1_prod [NTAPS];

    // Stage 2: products
    logic                 s2_valid, s2_rnd, s2_bypass;
    mode_e                s2_mode;
    logic [BIT_DEPTH-1:0] s2_center;
    logic signed [PROD_W-1:0] s2_prod [NTAPS];
    logic signed [SUM_W-1:0]  s2_total;

    // Stage 3: sum
    logic                 s3_valid, s3_rnd, s3_bypass;
    mode_e                s3_mode;
    logic [BIT_DEPTH-1:0] s3_center;
    logic signed [SUM_W-1:0] s3_sum;
    logic signed [15:0]   s3_result;

    // Output stage side-band kept for checking
    mode_e                o_mode;
    logic                 o_bypass;

    // Valid bits for every stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s2_valid  <= 1'b0;
            s3_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            s2_valid  <= s1_valid;
            s3_valid  <= s2_valid;
            out_valid <= s3_valid;
        end
    end

    // Stage 1 capture of controls and window.
    always_ff @(posedge clk) begin
        s1_mode  <= mode_e'(in_mode);
        s1_phase <= in_phase;
        s1_rnd   <= in_rnd;
        for (int i = 0; i < NTAPS; i++) s1_win[i] <= in_window[i*BIT_DEPTH +: BIT_DEPTH];
    end

    // Full-sample detection: chroma uses all phase bits, others the low two.
    always_comb begin
        s1_bypass = (s1_mode == MODE_HEVC_C) ? (s1_phase == 3'd0) : (s1_phase[1:0] == 2'd0);
    end

    genvar t;
    generate
        for (t = 0; t < NTAPS; t++) begin : g_tap
            assign s1_coef[t] = coef_of(s1_mode, s1_phase, 3'(t));
            subpel_tap_mul #(.BIT_DEPTH(BIT_DEPTH), .PROD_W(PROD_W)) u_mul (
                .x    (s1_win[t]),
                .coef (s1_coef[t]),
                .prod (s1_prod[t])
            );
        end
    endgenerate

    // Stage 2 register of products and side-band.
    always_ff @(posedge clk) begin
        s2_mode   <= s1_mode;
        s2_rnd    <= s1_rnd;
        s2_bypass <= s1_bypass;
        s2_center <= s1_win[3];
        for (int i = 0; i < NTAPS; i++) s2_prod[i] <= s1_prod[i];
    end

    subpel_adder_tree #(.N(NTAPS), .IN_W(PROD_W), .OUT_W(SUM_W)) u_tree (
        .terms (s2_prod),
        .total (s2_total)
    );

    // Stage 3 register of the tap sum.
    always_ff @(posedge clk) begin
        s3_mode   <= s2_mode;
        s3_rnd    <= s2_rnd;
        s3_bypass <= s2_bypass;
        s3_center <= s2_center;
        s3_sum    <= s2_total;
    end

    subpel_round_clip #(.BIT_DEPTH(BIT_DEPTH), .SUM_W(SUM_W), .OUT_W(16)) u_rc (
        .mode   (s3_mode),
        .rnd    (s3_rnd),
        .bypass (s3_bypass),
        .center (s3_center),
        .sum    (s3_sum),
        .result (s3_result)
    );

    // Output register.
    always_ff @(posedge clk) begin
        out_sample <= s3_result;
        o_mode     <= s3_mode;
        o_bypass   <= s3_bypass;
    end

    // Chroma products outside taps 2..5 must be zero (R3).
    a_r3_chroma_outer_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_mode == MODE_HEVC_C) |->
        (s2_prod[0] == 0 && s2_prod[1] == 0 && s2_prod[6] == 0 && s2_prod[7] == 0));

    // AVC outer taps contribute nothing (R4).
    a_r4_avc_outer_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_mode == MODE_AVC) |-> (s2_prod[0] == 0 && s2_prod[7] == 0));

    // Clipped families stay inside the sample range (R4, R5).
    a_r5_clip_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (o_mode == MODE_AVC || o_mode == MODE_MP4)) |->
        (out_sample >= 0 && out_sample <= 16'(MAXV)));

    // HEVC full-sample output is an upscaled sample (R6).
    a_r6_hevc_bypass_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && o_bypass && (o_mode == MODE_HEVC_Y || o_mode == MODE_HEVC_C)) |->
        (out_sample[UPSCALE-1:0] == '0 && out_sample >= 0));
endmodule

// File: tb/sim_mc_subpel_filter.sv
module sim_mc_subpel_filter;
    localparam int B = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_mode = '0;
    logic [2:0]    in_phase = '0;
    logic          in_rnd = 1'b0;
    logic [8*B-1:0] in_window = '0;
    logic          out_valid;
    logic signed [15:0] out_sample;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct { bit v; int val; string tag; } exp_t;
    exp_t q[$];

    mc_subpel_filter #(.BIT_DEPTH(B)) u0 (
        .clk, .rst_n, .in_valid, .in_mode, .in_phase, .in_rnd, .in_window,
        .out_valid, .out_sample
    );

    always #10 clk = ~clk;

    function automatic int smp(logic [8*B-1:0] w, int i);
        return int'(w[i*B +: B]);
    endfunction

    // Behavioural reference following the requirements.
    function automatic exp_t model(bit v, int m, int ph, int r, logic [8*B-1:0] w);
        exp_t e;
        int c [8];
        int frac, sum, t;
        e.v = v; e.val = 0;
        c = '{0, 0, 0, 0, 0, 0, 0, 0};
        frac = (m == 1) ? ph : (ph & 3);
        case (m)
            0: e.tag = "R2";
            1: e.tag = "R3";
            2: e.tag = "R4";
            default: e.tag = "R5";
        endcase
        if (!v) begin e.tag = "R9"; return e; end
        if (frac == 0) begin
            e.tag = "R6";
            e.val = (m < 2) ? smp(w, 3) * 64 : smp(w, 3);
            return e;
        end
        if (m == 0) begin
            if (frac == 1) c = '{-1, 4, -10, 58, 17, -5, 1, 0};
            else if (frac == 2) c = '{-1, 4, -11, 40, 40, -11, 4, -1};
            else c = '{0, 1, -5, 17, 58, -10, 4, -1};
        end else if (m == 1) begin
            case (frac)
                1: c = '{0, 0, -2, 58, 10, -2, 0, 0};
                2: c = '{0, 0, -4, 54, 16, -2, 0, 0};
                3: c = '{0, 0, -6, 46, 28, -4, 0, 0};
                4: c = '{0, 0, -4, 36, 36, -4, 0, 0};
                5: c = '{0, 0, -4, 28, 46, -6, 0, 0};
                6: c = '{0, 0, -2, 16, 54, -4, 0, 0};
                default: c = '{0, 0, -2, 10, 58, -2, 0, 0};
            endcase
        end else if (m == 2) c = '{0, 1, -5, 20, 20, -5, 1, 0};
        else c = '{-1, 3, -6, 20, 20, -6, 3, -1};
        sum = 0;
        for (int i = 0; i < 8; i++) sum += c[i] * smp(w, i);
        if (m < 2) e.val = sum;
        else begin
            t = (sum + 16 - ((m == 3) ? r : 0)) >>> 5;
            e.val = (t < 0) ? 0 : (t > 255) ? 255 : t;
        end
        return e;
    endfunction

    // Model pipeline: push the expectation for the inputs seen at each edge.
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            e.v = 0; e.val = 0; e.tag = "R8";
            q.delete();
            for (int i = 0; i < 4; i++) q.push_back(e);
        end else begin
            e = model(in_valid, int'(in_mode), int'(in_phase), int'(in_rnd), in_window);
            if (q.size() >= 4) void'(q.pop_front());
            q.push_back(e);
        end
    end

    // Compare away from the active edge against the entry of three edges ago.
    always @(negedge clk) begin
        if (q.size() == 4 && !finished) begin
            exp_t e;
            e = q[0];
            n_cmp++;
            if (out_valid !== e.v) begin
                n_bad++;
                $display("FAIL %s (R1/valid): out_valid=%0b expected=%0b", e.tag, out_valid, e.v);
            end else if (e.v && int'(out_sample) != e.val) begin
                n_bad++;
                $display("FAIL %s: out_sample=%0d expected=%0d", e.tag, out_sample, e.val);
            end
        end
    end

    task automatic drive(bit v, int m, int ph, bit r, logic [8*B-1:0] w);
        @(negedge clk);
        in_valid  = v;
        in_mode   = 2'(m);
        in_phase  = 3'(ph);
        in_rnd    = r;
        in_window = w;
    endtask

    function automatic logic [8*B-1:0] pack(int a0, int a1, int a2, int a3,
                                            int a4, int a5, int a6, int a7);
        return {8'(a7), 8'(a6), 8'(a5), 8'(a4), 8'(a3), 8'(a2), 8'(a1), 8'(a0)};
    endfunction

    initial begin
        logic [8*B-1:0] ramp;
        ramp = pack(10, 20, 30, 40, 50, 60, 70, 80);
        // R8: reset holds out_valid low while windows are offered
        for (int i = 0; i < 4; i++) drive(1, 0, 2, 0, ramp);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R8: out_valid=%0b expected=0", out_valid);
        end
        // R2 luma phases, with phase bit 2 set to show it is ignored
        for (int p = 0; p < 8; p++) drive(1, 0, p, 0, ramp);
        // R3 chroma phases; outer taps large to show they are ignored
        for (int p = 0; p < 8; p++) drive(1, 1, p, 0, pack(255, 255, 12, 200, 34, 9, 255, 255));
        // R4 clip high and low, R5 with both rounding settings
        drive(1, 2, 2, 0, pack(0, 0, 0, 255, 255, 0, 0, 0));
        drive(1, 2, 1, 0, pack(0, 0, 255, 0, 0, 255, 0, 0));
        drive(1, 2, 3, 1, pack(255, 5, 6, 7, 8, 9, 10, 255));
        drive(1, 3, 2, 0, pack(0, 0, 0, 255, 255, 0, 0, 0));
        drive(1, 3, 2, 0, pack(0, 0, 255, 0, 0, 255, 0, 0));
        drive(1, 3, 2, 0, pack(1, 0, 0, 1, 0, 0, 0, 0));
        drive(1, 3, 2, 1, pack(1, 0, 0, 1, 0, 0, 0, 0));
        // R6 bypass in every mode
        for (int m = 0; m < 4; m++) drive(1, m, (m == 1) ? 0 : 4, 1, pack(9, 9, 9, 173, 9, 9, 9, 9));
        // R9 bubble then R7 back-to-back mode switch
        drive(0, 0, 1, 0, ramp);
        for (int m = 0; m < 4; m++) drive(1, m, 2, 1, ramp);
        // R7/R9 random run: modes, phases, rounding, gaps all vary
        for (int k = 0; k < 3000; k++) begin
            drive(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 8),
                  1'($urandom), {$urandom, $urandom});
        end
        drive(0, 0, 0, 0, '0);
        repeat (6) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL R1: watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule